// File: doc/BRIEF.md
# Threshold-Pruned Adaptive Add-Compare-Select Unit

This unit performs the add-compare-select step of a hard-decision, rate-1/2 adaptive Viterbi decoder. It does not keep one metric per trellis state. Instead it holds a short list of at most `NMAX` survivor paths. Each list entry carries a valid flag, a state tag and an accumulated error metric.

When a 2-bit received symbol is accepted, every valid survivor is extended along both input-bit branches. Each branch adds its Hamming distance to the path metric. Extensions that land on the same trellis state are merged. The remaining extensions are then screened against the previous best metric plus a threshold. If too many pass, the threshold is lowered in steps of two and the screen is repeated, one pass per clock, without sorting.

The surviving list is presented on the output together with per-entry decision bits and parent indices, which feed a separate survivor memory, and the new minimum metric. A valid/ready pair handshakes both the symbol input and the list output.

Top module: `adaptive_acs`

## Requirements
- R1: After reset the list holds exactly one valid entry, in slot 0, with state 0 and metric 0. `out_valid` is 0, `sym_ready` is 1 and `out_min` is 0.
- R2: An extension of a parent with state `s` on input bit `u` forms the K-bit window `w = {u, s}`. Its expected code is `{^(w & G0), ^(w & G1)}`, with bit 1 from `G0`, and it reaches next state `w[K-1:1]`. Its metric is the parent metric plus the Hamming distance between that code and `sym`. The sum saturates at 2^MW-1.
- R3: An extension is retained only if its metric is strictly less than dm + thr. Here dm is the smallest metric among the valid entries of the current list, and thr is the threshold in force. At least one entry is always retained.
- R4: When several extensions reach the same next state, only the one with the smallest metric may be retained. On equal metrics the extension with the lower parent slot index wins.
- R5: Each symbol starts with thr = `THRESH`. Each evaluation pass takes one clock. While more than `NMAX` merged extensions pass and thr is at least 4, thr drops by 2 and another pass follows. `out_valid` rises 1 + (number of reductions) clocks after the accepting edge.
- R6: If more than `NMAX` extensions still pass when lowering stops, only the first `NMAX` in candidate order are kept.
- R7: The candidate index is 2*parent_slot + u. Retained extensions fill slots 0 upward in increasing candidate index, and unused slots are invalid. Each slot reports the next state, the metric, `out_dec` = u and `out_parent` = parent slot.
- R8: `out_min` equals the smallest metric among the valid output entries.
- R9: While `out_valid` is high and `out_ready` is low, the list and `out_min` hold steady, `sym_ready` is low and no symbol is accepted.
- R10: Metrics never wrap. After a long run of uncorrelated symbols, `out_min` reaches and stays at 2^MW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| sym_valid | input | 1 | Received symbol is present |
| sym_ready | output | 1 | Unit can accept a symbol |
| sym | input | 2 | Hard-decision received symbol pair |
| out_valid | output | 1 | New survivor list is presented |
| out_ready | input | 1 | Consumer takes the list |
| out_vld | output | NMAX | Valid flag per slot |
| out_state | output | NMAX*(K-1) | State tag per slot, slot i at bits [i*(K-1) +: K-1] |
| out_metric | output | NMAX*MW | Accumulated metric per slot |
| out_dec | output | NMAX | Decision (input) bit per slot |
| out_parent | output | NMAX*PW | Parent slot index per slot, PW = clog2(NMAX) |
| out_min | output | MW | Smallest valid metric of the list |

## Verification
The survivor list registers drive the output ports directly. A wrong state tag, metric, decision or parent therefore appears in the very handshake that produced it. A lost or duplicated survivor corrupts every later list, because the next extension step starts from it.

An error in the threshold sequence shows up as a wrong distance from acceptance to `out_valid`, or as a wrong count of valid slots, within that same symbol. A stale or miscomputed minimum shifts the screen of the following symbol. Comparing every slot after every symbol against an independent model catches that one symbol later at most.

// File: rtl/acs_pkg.sv
package acs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_HOLD = 2'd2
  } acs_phase_e;

  // Hamming distance between two 2-bit words
  function automatic logic [1:0] hamming2(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] x;
    x = a ^ b;
    return {1'b0, x[1]} + {1'b0, x[0]};
  endfunction

endpackage

// File: rtl/acs_branch_gen.sv
module acs_branch_gen import acs_pkg::*; #(
  parameter int K = 4,
  parameter int NMAX = 4,
  parameter int MW = 8,
  parameter logic [K-1:0] G0 = 4'b1111,
  parameter logic [K-1:0] G1 = 4'b1101,
  localparam int SW = K - 1,
  localparam int NC = 2 * NMAX
) (
  input  logic [NMAX-1:0] vld_i,
  input  logic [SW-1:0]   state_i  [NMAX],
  input  logic [MW-1:0]   metric_i [NMAX],
  input  logic [1:0]      sym_i,
  output logic [NC-1:0]   c_vld_o,
  output logic [SW-1:0]   c_state_o  [NC],
  output logic [MW-1:0]   c_metric_o [NC]
);

  for (genvar p = 0; p < NMAX; p++) begin : g_par
    for (genvar u = 0; u < 2; u++) begin : g_bit
      logic [K-1:0] w;
      logic [1:0]   code;
      logic [MW:0]  sum;
      assign w    = {1'(u), state_i[p]};
      assign code = {^(w & G0), ^(w & G1)};
      assign sum  = {1'b0, metric_i[p]} + {{(MW-1){1'b0}}, hamming2(code, sym_i)};
      assign c_vld_o[2*p+u]    = vld_i[p];
      assign c_state_o[2*p+u]  = w[K-1:1];
      assign c_metric_o[2*p+u] = sum[MW] ? {MW{1'b1}} : sum[MW-1:0];
    end
  end

endmodule

// File: rtl/acs_prune.sv
module acs_prune #(
  parameter int SW = 3,
  parameter int MW = 8,
  parameter int NMAX = 4,
  parameter int TW = 4,
  localparam int NC = 2 * NMAX,
  localparam int CIW = $clog2(NC),
  localparam int CW = $clog2(NC + 1)
) (
  input  logic [NC-1:0]  c_vld_i,
  input  logic [SW-1:0]  c_state_i  [NC],
  input  logic [MW-1:0]  c_metric_i [NC],
  input  logic [MW-1:0]  dm_i,
  input  logic [TW-1:0]  thr_i,
  output logic [CW-1:0]  cnt_o,
  output logic [NMAX-1:0] s_vld_o,
  output logic [SW-1:0]  s_state_o  [NMAX],
  output logic [MW-1:0]  s_metric_o [NMAX],
  output logic [CIW-1:0] s_cidx_o   [NMAX]
);

  logic [NC-1:0] win;
  logic [NC-1:0] qual;
  logic [MW+1:0] lim;

  // merge: a candidate loses to any other reaching the same state with a
  // smaller metric, or an equal metric from a lower candidate index
  always_comb begin
    win = c_vld_i;
    for (int j = 0; j < NC; j++) begin
      for (int k = 0; k < NC; k++) begin
        if (k != j && c_vld_i[k] && c_state_i[k] == c_state_i[j] &&
            (c_metric_i[k] < c_metric_i[j] || (c_metric_i[k] == c_metric_i[j] && k < j)))
          win[j] = 1'b0;
      end
    end
  end

  assign lim = {2'b00, dm_i} + (MW+2)'(thr_i);

  always_comb begin
    cnt_o = '0;
    for (int j = 0; j < NC; j++) begin
      qual[j] = win[j] && ({2'b00, c_metric_i[j]} < lim);
      cnt_o   = cnt_o + CW'(qual[j]);
    end
  end

  // compaction: the n-th qualifying candidate goes to slot n, first NMAX only
  always_comb begin
    int rank;
    rank     = 0;
    s_vld_o  = '0;
    for (int i = 0; i < NMAX; i++) begin
      s_state_o[i]  = '0;
      s_metric_o[i] = '0;
      s_cidx_o[i]   = '0;
    end
    for (int j = 0; j < NC; j++) begin
      if (qual[j]) begin
        if (rank < NMAX) begin
          s_vld_o[rank]    = 1'b1;
          s_state_o[rank]  = c_state_i[j];
          s_metric_o[rank] = c_metric_i[j];
          s_cidx_o[rank]   = CIW'(j);
        end
        rank = rank + 1;
      end
    end
  end

endmodule

// File: rtl/acs_min.sv
module acs_min #(
  parameter int NMAX = 4,
  parameter int MW = 8
) (
  input  logic [NMAX-1:0] vld_i,
  input  logic [MW-1:0]   metric_i [NMAX],
  output logic [MW-1:0]   min_o
);

  always_comb begin
    min_o = {MW{1'b1}};
    for (int i = 0; i < NMAX; i++) begin
      if (vld_i[i] && metric_i[i] < min_o) min_o = metric_i[i];
    end
  end

endmodule

// File: rtl/adaptive_acs.sv
module adaptive_acs import acs_pkg::*; #(
  parameter int K = 4,
  parameter int NMAX = 4,
  parameter int MW = 8,
  parameter int THRESH = 14,
  parameter logic [K-1:0] G0 = 4'b1111,
  parameter logic [K-1:0] G1 = 4'b1101,
  localparam int SW = K - 1,
  localparam int PW = (NMAX > 1) ? $clog2(NMAX) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sym_valid,
  output logic                 sym_ready,
  input  logic [1:0]           sym,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NMAX-1:0]      out_vld,
  output logic [NMAX*SW-1:0]   out_state,
  output logic [NMAX*MW-1:0]   out_metric,
  output logic [NMAX-1:0]      out_dec,
  output logic [NMAX*PW-1:0]   out_parent,
  output logic [MW-1:0]        out_min
);

  localparam int NC  = 2 * NMAX;
  localparam int CIW = $clog2(NC);
  localparam int CW  = $clog2(NC + 1);
  localparam int TW  = $clog2(THRESH + 1);

  acs_phase_e      phase_q, phase_d;
  logic [1:0]      sym_q;
  logic [TW-1:0]   thr_q, thr_d;
  logic            load_en, thr_en, commit;

  logic [NMAX-1:0] vld_q;
  logic [SW-1:0]   st_q  [NMAX];
  logic [MW-1:0]   met_q [NMAX];
  logic [NMAX-1:0] dec_q;
  logic [PW-1:0]   par_q [NMAX];
  logic [MW-1:0]   dm;

  logic [NC-1:0]   c_vld;
  logic [SW-1:0]   c_state  [NC];
  logic [MW-1:0]   c_metric [NC];
  logic [CW-1:0]   cnt;
  logic [NMAX-1:0] s_vld;
  logic [SW-1:0]   s_state  [NMAX];
  logic [MW-1:0]   s_metric [NMAX];
  logic [CIW-1:0]  s_cidx   [NMAX];

  acs_branch_gen #(.K(K), .NMAX(NMAX), .MW(MW), .G0(G0), .G1(G1)) i_branch (
    .vld_i(vld_q), .state_i(st_q), .metric_i(met_q), .sym_i(sym_q),
    .c_vld_o(c_vld), .c_state_o(c_state), .c_metric_o(c_metric)
  );

  acs_min #(.NMAX(NMAX), .MW(MW)) i_min (
    .vld_i(vld_q), .metric_i(met_q), .min_o(dm)
  );

  acs_prune #(.SW(SW), .MW(MW), .NMAX(NMAX), .TW(TW)) i_prune (
    .c_vld_i(c_vld), .c_state_i(c_state), .c_metric_i(c_metric),
    .dm_i(dm), .thr_i(thr_q), .cnt_o(cnt),
    .s_vld_o(s_vld), .s_state_o(s_state), .s_metric_o(s_metric), .s_cidx_o(s_cidx)
  );

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    thr_d   = thr_q;
    load_en = 1'b0;
    thr_en  = 1'b0;
    commit  = 1'b0;
    unique case (phase_q)
      ST_IDLE: begin
        if (sym_valid) begin
          load_en = 1'b1;
          thr_en  = 1'b1;
          thr_d   = TW'(THRESH);
          phase_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (int'(cnt) <= NMAX || int'(thr_q) < 4) begin
          commit  = 1'b1;
          phase_d = ST_HOLD;
        end else begin
          thr_en = 1'b1;
          thr_d  = thr_q - TW'(2);
        end
      end
      ST_HOLD: begin
        if (out_ready) phase_d = ST_IDLE;
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      sym_q   <= '0;
      thr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (load_en) sym_q <= sym;
      if (thr_en)  thr_q <= thr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= NMAX'(1);
      dec_q <= '0;
      for (int i = 0; i < NMAX; i++) begin
        st_q[i]  <= '0;
        met_q[i] <= '0;
        par_q[i] <= '0;
      end
    end else if (commit) begin
      vld_q <= s_vld;
      for (int i = 0; i < NMAX; i++) begin
        st_q[i]  <= s_state[i];
        met_q[i] <= s_metric[i];
        dec_q[i] <= s_cidx[i][0];
        par_q[i] <= PW'(s_cidx[i] >> 1);
      end
    end
  end

  // outputs
  assign sym_ready = (phase_q == ST_IDLE);
  assign out_valid = (phase_q == ST_HOLD);
  assign out_vld   = vld_q;
  assign out_dec   = dec_q;
  assign out_min   = dm;

  for (genvar i = 0; i < NMAX; i++) begin : g_out
    assign out_state[i*SW +: SW]  = st_q[i];
    assign out_metric[i*MW +: MW] = met_q[i];
    assign out_parent[i*PW +: PW] = par_q[i];
  end

endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
  parameter int NMAX = 4,
  parameter int MW = 8,
  parameter int THRESH = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sym_valid,
  input logic                 sym_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [NMAX-1:0]      out_vld,
  input logic [NMAX*MW-1:0]   out_metric,
  input logic [MW-1:0]        out_min
);

  localparam int LW = $clog2(THRESH + 2) + 1;
  localparam int MAXPASS = THRESH / 2;

  logic [LW-1:0] pass_cnt;
  logic [MW-1:0] min_at_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_cnt      <= '0;
      min_at_accept <= '0;
    end else if (sym_valid && sym_ready) begin
      pass_cnt      <= '0;
      min_at_accept <= out_min;
    end else if (!sym_ready && !out_valid && pass_cnt != {LW{1'b1}}) begin
      pass_cnt <= pass_cnt + 1'b1;
    end
  end

  AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_ready && !out_valid) |-> (int'(pass_cnt) < MAXPASS)); // R5

  AST_LIST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vld) && $stable(out_metric) && $stable(out_min))); // R9

  AST_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vld != '0)); // R3

  AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_vld & (out_vld + 1'b1)) == '0)); // R7

  AST_MIN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_min >= min_at_accept)); // R10

endmodule

bind adaptive_acs acs_checker #(.NMAX(NMAX), .MW(MW), .THRESH(THRESH)) i_acs_checker (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_vld(out_vld),
  .out_metric(out_metric), .out_min(out_min)
);

// File: tb/test_adaptive_acs.sv
module test_adaptive_acs;

  localparam int K = 4;
  localparam int NMAX = 4;
  localparam int MW = 8;
  localparam int THRESH = 14;
  localparam logic [K-1:0] G0 = 4'b1111;
  localparam logic [K-1:0] G1 = 4'b1101;
  localparam int SW = K - 1;
  localparam int PW = 2;
  localparam int NC = 2 * NMAX;
  localparam int NS = 1 << SW;
  localparam int MAXM = (1 << MW) - 1;

  // {sym[1:0], expected min[7:0], expected valid count[3:0], expected reductions[3:0]}
  localparam logic [17:0] TBL [3] = '{
    {2'b11, 8'd0, 4'd2, 4'd0},
    {2'b11, 8'd0, 4'd4, 4'd0},
    {2'b00, 8'd1, 4'd2, 4'd6}
  };

  logic clk, rst_n, sym_valid, sym_ready, out_valid, out_ready;
  logic [1:0] sym;
  logic [NMAX-1:0] out_vld, out_dec;
  logic [NMAX*SW-1:0] out_state;
  logic [NMAX*MW-1:0] out_metric;
  logic [NMAX*PW-1:0] out_parent;
  logic [MW-1:0] out_min;

  adaptive_acs #(.K(K), .NMAX(NMAX), .MW(MW), .THRESH(THRESH), .G0(G0), .G1(G1)) i_adaptive_acs (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready), .sym(sym),
    .out_valid(out_valid), .out_ready(out_ready), .out_vld(out_vld), .out_state(out_state),
    .out_metric(out_metric), .out_dec(out_dec), .out_parent(out_parent), .out_min(out_min)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_run, n_fail;
  bit done;
  logic [15:0] lf;

  int m_vld [NMAX];
  int m_st  [NMAX];
  int m_met [NMAX];
  int e_dec [NMAX];
  int e_par [NMAX];
  int e_low;
  bit e_trunc;

  function automatic int parity(input int x);
    return $countones(x) & 1;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NMAX; i++) begin
      m_vld[i] = (i == 0) ? 1 : 0;
      m_st[i] = 0; m_met[i] = 0; e_dec[i] = 0; e_par[i] = 0;
    end
  endtask

  function automatic int model_min();
    int m;
    m = MAXM;
    for (int i = 0; i < NMAX; i++) if (m_vld[i] != 0 && m_met[i] < m) m = m_met[i];
    return m;
  endfunction

  task automatic model_step(input logic [1:0] s);
    int cm [NC]; int cs [NC]; int cv [NC]; int bst [NS];
    int dm, thr, cnt, slot, w, code;
    for (int st = 0; st < NS; st++) bst[st] = -1;
    for (int p = 0; p < NMAX; p++) begin
      for (int u = 0; u < 2; u++) begin
        int j;
        j = 2 * p + u;
        w = (u << SW) | m_st[p];
        code = (parity(w & int'(G0)) << 1) | parity(w & int'(G1));
        cv[j] = m_vld[p];
        cs[j] = w >> 1;
        cm[j] = m_met[p] + $countones(code ^ int'(s));
        if (cm[j] > MAXM) cm[j] = MAXM;
      end
    end
    for (int j = 0; j < NC; j++) begin
      if (cv[j] != 0) begin
        if (bst[cs[j]] < 0) bst[cs[j]] = j;
        else if (cm[j] < cm[bst[cs[j]]]) bst[cs[j]] = j;
      end
    end
    dm = model_min();
    thr = THRESH;
    e_low = 0;
    while (1) begin
      cnt = 0;
      for (int st = 0; st < NS; st++) if (bst[st] >= 0 && cm[bst[st]] < dm + thr) cnt++;
      if (cnt <= NMAX || thr < 4) break;
      thr -= 2;
      e_low++;
    end
    e_trunc = (cnt > NMAX);
    model_reset();
    m_vld[0] = 0;
    slot = 0;
    for (int j = 0; j < NC; j++) begin
      if (cv[j] != 0 && bst[cs[j]] == j && cm[j] < dm + thr && slot < NMAX) begin
        m_vld[slot] = 1; m_st[slot] = cs[j]; m_met[slot] = cm[j];
        e_dec[slot] = j % 2; e_par[slot] = j / 2;
        slot++;
      end
    end
  endtask

  task automatic check_list();
    for (int i = 0; i < NMAX; i++) begin
      check("R7", "slot valid", int'(out_vld[i]), m_vld[i]);
      if (m_vld[i] != 0) begin
        check("R4", "slot state", int'(out_state[i*SW +: SW]), m_st[i]);
        check("R2", "slot metric", int'(out_metric[i*MW +: MW]), m_met[i]);
        check("R7", "slot decision", int'(out_dec[i]), e_dec[i]);
        check("R7", "slot parent", int'(out_parent[i*PW +: PW]), e_par[i]);
      end
    end
    check("R8", "minimum", int'(out_min), model_min());
    if (e_trunc) check("R6", "truncated count", $countones(out_vld), NMAX);
  endtask

  task automatic check_reset();
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "sym_ready", int'(sym_ready), 1);
    check("R1", "valid flags", int'(out_vld), 1);
    check("R1", "slot0 state", int'(out_state[SW-1:0]), 0);
    check("R1", "slot0 metric", int'(out_metric[MW-1:0]), 0);
    check("R1", "minimum", int'(out_min), 0);
  endtask

  task automatic send(input logic [1:0] s, output int lat);
    while (!sym_ready) @(negedge clk);
    sym_valid = 1'b1;
    sym = s;
    @(posedge clk);
    @(negedge clk);
    sym_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic release_out();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic step(input logic [1:0] s, input bit hold);
    int lat;
    model_step(s);
    send(s, lat);
    check("R5", "latency", lat, 1 + e_low);
    check_list();
    if (hold) begin
      for (int c = 0; c < 3; c++) begin
        sym_valid = 1'b1;
        sym = ~s;
        @(negedge clk);
        check("R9", "out_valid held", int'(out_valid), 1);
        check("R9", "sym_ready low", int'(sym_ready), 0);
        check("R9", "min held", int'(out_min), model_min());
      end
      sym_valid = 1'b0;
    end
    release_out();
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int lat, es, w, code;
    n_run = 0; n_fail = 0; done = 0;
    lf = 16'hACE1;
    rst_n = 1'b0; sym_valid = 1'b0; out_ready = 1'b0; sym = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_reset();
    check_reset();

    // table of hand-worked vectors
    for (int i = 0; i < 3; i++) begin
      logic [1:0] s;
      s = TBL[i][17:16];
      model_step(s);
      send(s, lat);
      check("R5", "table reductions", lat, 1 + int'(TBL[i][3:0]));
      check("R8", "table minimum", int'(out_min), int'(TBL[i][15:8]));
      check("R3", "table survivor count", $countones(out_vld), int'(TBL[i][7:4]));
      check_list();
      release_out();
    end

    // back-pressure: a held list ignores a waiting symbol (R9)
    step(2'b10, 1'b1);
    step(2'b01, 1'b0);

    // encoded stream with sparse bit errors
    es = 0;
    for (int n = 0; n < 300; n++) begin
      w = (int'(lf[0]) << SW) | es;
      code = (parity(w & int'(G0)) << 1) | parity(w & int'(G1));
      if (lf[7:4] == 4'd0) code = code ^ (lf[8] ? 2 : 1);
      es = w >> 1;
      lf = lfsr_next(lf);
      step(2'(code), 1'b0);
    end

    // uncorrelated symbols drive metrics into saturation
    for (int n = 0; n < 2300; n++) begin
      lf = lfsr_next(lf);
      step(lf[1:0], 1'b0);
    end
    check("R10", "saturated minimum", int'(out_min), MAXM);

    // reset during an evaluation pass
    while (!sym_ready) @(negedge clk);
    sym_valid = 1'b1; sym = 2'b11;
    @(posedge clk);
    @(negedge clk);
    sym_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    @(negedge clk);
    model_reset();
    step(2'b11, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule